// File: doc/BRIEF.md
# Input Capture Timer Channel

This block is a 16-bit up-counter with a programmable clock divider, a programmable reload limit and one input-capture channel. A clean rising edge on the capture pin stores the current count in a capture register. Software uses two successive captures, together with the number of counter wraps between them, to measure the period of an external signal over a range wider than the counter itself.

Software reaches the block through a small single-cycle register port. Three status flags record counter wrap, capture, and overcapture, which marks a capture that replaced one that was never read. A flag is cleared by writing 0 to its bit. Writing 1 leaves the flag as it is, so a handler can write back the bitwise inverse of the status it read and clear only the events it has handled. Reading the capture register also clears the capture flag. One interrupt line combines the enabled flags.

Register addresses: 0 control (bit0 run, bit1 capture enable, bits 7:4 filter length F), 1 interrupt enables (bit0 wrap, bit1 capture), 2 status (bit0 wrap flag, bit1 capture flag, bit2 overcapture flag), 3 divider, 4 reload limit, 5 counter, 6 capture (read only).

Top module: `ict_capture_timer`

## Requirements
- R1: After reset the counter, divider, capture register, control, enables and all status flags read 0, the reload limit reads 65535, and irq is low.
- R2: While run (control bit0) is set and the divider holds N, the counter advances once every N+1 clocks. While run is clear, the counter holds its value.
- R3: On an advance from a count at or above the reload limit, the counter goes to 0 and status bit0 is set on the same clock edge.
- R4: The capture pin passes through a two-stage synchronizer and then a filter. The filter accepts a new level only after F+1 consecutive synchronized samples at that level, where F is control bits 7:4. A high pulse shorter than that causes no capture.
- R5: An accepted rising edge, with run and capture enable set, copies into the capture register the count held just before that clock edge.
- R6: A capture sets status bit1. A read of address 6 clears status bit1.
- R7: A capture sets status bit2 when status bit1 is already set and is not being cleared on that same edge.
- R8: Writing address 2 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A hardware event on the same edge as a clear of its flag wins.
- R9: irq is high exactly when (status bit0 AND enable bit0) OR (status bit1 AND enable bit1).
- R10: No capture happens unless run and capture enable are both set. A falling edge never captures.
- R11: Writing address 5 loads the counter and restarts the divide-by-(N+1) sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are those where a hardware event and a software clear land on the same clock edge. Examples are a counter wrap during a status write of 0, or a second capture during the read of the capture register. The stimulus sets a reload limit of 1 with no division, so a wrap happens every other clock, and issues clearing writes on back-to-back clocks. It then runs a long random mix of capture pulses, reads and writes. A cycle-accurate model is compared on every clock, so each collision is checked when it occurs. Pulses of exactly F and F+1 clocks test the filter threshold.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam int FILT_W = 4;
  localparam int FLAG_N = 3;
  localparam int F_UPD  = 0;
  localparam int F_CAP  = 1;
  localparam int F_OVC  = 2;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_DIV  = 3'd3,
    A_LIM  = 3'd4,
    A_CNT  = 3'd5,
    A_CAP  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [FILT_W-1:0] flen;
    logic              cap_en;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/ict_tick_counter.sv
module ict_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] div,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap_evt
);
  logic [W-1:0] pc_q, pc_d, cnt_q, cnt_d;
  logic         tick;

  always_comb begin
    tick     = run && (pc_q >= div);
    wrap_evt = tick && (cnt_q >= lim);
    pc_d     = pc_q;
    cnt_d    = cnt_q;
    if (load) begin
      cnt_d = load_val;
      pc_d  = '0;
    end else if (tick) begin
      pc_d  = '0;
      cnt_d = wrap_evt ? '0 : cnt_q + 1'b1;
    end else if (run) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ict_edge_filter.sv
module ict_edge_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [FW-1:0] flen,
  output logic          rise
);
  logic          s1_q, s2_q, lvl_q, lvl_d;
  logic [FW-1:0] rc_q, rc_d;

  always_comb begin
    lvl_d = lvl_q;
    rc_d  = '0;
    rise  = 1'b0;
    if (s2_q != lvl_q) begin
      if (rc_q >= flen) begin
        lvl_d = s2_q;
        rise  = s2_q;
      end else begin
        rc_d = rc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      rc_q  <= '0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      rc_q  <= rc_d;
    end
  end
endmodule

// File: rtl/ict_flag_bank.sv
module ict_flag_bank
  import ict_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_evt,
  input  logic              cap_evt,
  input  logic              stat_wr,
  input  logic [FLAG_N-1:0] stat_wd,
  input  logic              cap_rd,
  input  logic [1:0]        ien,
  output logic [FLAG_N-1:0] flags,
  output logic              irq
);
  logic [FLAG_N-1:0] fl_q, fl_d;
  logic [FLAG_N-1:0] clr;

  always_comb begin
    clr        = stat_wr ? ~stat_wd : '0;
    clr[F_CAP] = clr[F_CAP] | cap_rd;
    fl_d       = fl_q & ~clr;
    if (upd_evt) fl_d[F_UPD] = 1'b1;
    if (cap_evt) begin
      fl_d[F_CAP] = 1'b1;
      if (fl_q[F_CAP] && !clr[F_CAP]) fl_d[F_OVC] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags = fl_q;
  assign irq   = (fl_q[F_UPD] & ien[0]) | (fl_q[F_CAP] & ien[1]);
endmodule

// File: rtl/ict_capture_timer.sv
module ict_capture_timer
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cap_in,
  output logic             irq
);
  localparam logic [CNT_W-1:0] LIM_RST = {CNT_W{1'b1}};

  logic              rs1_q, rst_sync_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [1:0]        ien_q, ien_d;
  logic [CNT_W-1:0]  div_q, div_d, lim_q, lim_d, cap_q, cap_d;
  logic [CNT_W-1:0]  cnt;
  logic              upd_evt, rise, cap_evt, stat_wr, cap_rd, cnt_ld;
  logic [FLAG_N-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  assign stat_wr = reg_wr && (reg_addr == A_STAT);
  assign cnt_ld  = reg_wr && (reg_addr == A_CNT);
  assign cap_rd  = reg_rd && (reg_addr == A_CAP);
  assign cap_evt = rise && ctrl_q.run && ctrl_q.cap_en;

  ict_tick_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(ctrl_q.run), .load(cnt_ld),
    .load_val(reg_wdata), .div(div_q), .lim(lim_q), .cnt(cnt), .wrap_evt(upd_evt)
  );

  ict_edge_filter #(.FW(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_sync_n), .din(cap_in), .flen(ctrl_q.flen), .rise(rise)
  );

  ict_flag_bank u_flags (
    .clk(clk), .rst_n(rst_sync_n), .upd_evt(upd_evt), .cap_evt(cap_evt),
    .stat_wr(stat_wr), .stat_wd(reg_wdata[FLAG_N-1:0]), .cap_rd(cap_rd),
    .ien(ien_q), .flags(flags), .irq(irq)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    ien_d  = ien_q;
    div_d  = div_q;
    lim_d  = lim_q;
    cap_d  = cap_evt ? cnt : cap_q;
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL: ctrl_d = '{flen: reg_wdata[7:4], cap_en: reg_wdata[1], run: reg_wdata[0]};
        A_IEN:  ien_d  = reg_wdata[1:0];
        A_DIV:  div_d  = reg_wdata;
        A_LIM:  lim_d  = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      div_q  <= '0;
      lim_q  <= LIM_RST;
      cap_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
      div_q  <= div_d;
      lim_q  <= lim_d;
      cap_q  <= cap_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[7:0] = {ctrl_q.flen, 2'b00, ctrl_q.cap_en, ctrl_q.run};
      A_IEN:  reg_rdata[1:0] = ien_q;
      A_STAT: reg_rdata[FLAG_N-1:0] = flags;
      A_DIV:  reg_rdata = div_q;
      A_LIM:  reg_rdata = lim_q;
      A_CNT:  reg_rdata = cnt;
      A_CAP:  reg_rdata = cap_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/ict_capture_timer_chk.sv
module ict_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_evt,
  input logic             cap_evt,
  input logic             stat_wr,
  input logic [2:0]       stat_wd,
  input logic             cap_rd,
  input logic [2:0]       flags,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap_q,
  input logic             irq
);
  // R3
  upd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> flags[0]);
  // R5
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt)));
  // R6
  cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flags[1]);
  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && !cap_rd) |=> ((flags & $past(flags)) == $past(flags)));
  // R8
  ones_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wd == 3'b111 && !cap_rd) |=> ((flags & $past(flags)) == $past(flags)));
  // R7
  ovc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(cap_evt));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[0] || flags[1]));
endmodule

bind ict_capture_timer ict_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .upd_evt(upd_evt), .cap_evt(cap_evt),
  .stat_wr(stat_wr), .stat_wd(reg_wdata[2:0]), .cap_rd(cap_rd),
  .flags(flags), .cnt(cnt), .cap_q(cap_q), .irq(irq)
);

// File: tb/ict_capture_timer_test.sv
module ict_capture_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, cap_in = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit started = 0;

  always #10 clk = ~clk;

  ict_capture_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .irq(irq)
  );

  // behavioural reference model
  int m_run, m_cen, m_flen, m_ien, m_div, m_lim, m_cnt, m_pc, m_cap;
  int m_upd, m_capf, m_ovc, m_lvl, m_rc;
  int hist[$];

  task automatic m_reset();
    m_run = 0; m_cen = 0; m_flen = 0; m_ien = 0; m_div = 0; m_lim = 65535;
    m_cnt = 0; m_pc = 0; m_cap = 0; m_upd = 0; m_capf = 0; m_ovc = 0;
    m_lvl = 0; m_rc = 0;
    hist = {0, 0};
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return (m_flen << 4) | (m_cen << 1) | m_run;
      1: return m_ien;
      2: return (m_ovc << 2) | (m_capf << 1) | m_upd;
      3: return m_div;
      4: return m_lim;
      5: return m_cnt;
      6: return m_cap;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int s2, tick, upd_ev, rise, cap_ev, wrst, clr_cap, wd, a;
      wd = reg_wdata; a = reg_addr;
      s2 = hist[0];
      tick = m_run && (m_pc >= m_div);
      upd_ev = tick && (m_cnt >= m_lim);
      rise = 0;
      if (s2 != m_lvl) begin
        if (m_rc >= m_flen) begin m_lvl = s2; m_rc = 0; rise = s2; end
        else m_rc = m_rc + 1;
      end else m_rc = 0;
      cap_ev = rise && m_run && m_cen;
      wrst = reg_wr && a == 2;
      clr_cap = (reg_rd && a == 6) || (wrst && !wd[1]);
      if (cap_ev && m_capf && !clr_cap) m_ovc = 1;
      else if (wrst && !wd[2]) m_ovc = 0;
      if (cap_ev) begin m_capf = 1; m_cap = m_cnt; end
      else if (clr_cap) m_capf = 0;
      if (upd_ev) m_upd = 1;
      else if (wrst && !wd[0]) m_upd = 0;
      if (reg_wr && a == 5) begin m_cnt = wd; m_pc = 0; end
      else if (tick) begin m_pc = 0; m_cnt = upd_ev ? 0 : m_cnt + 1; end
      else if (m_run) m_pc = m_pc + 1;
      if (reg_wr) begin
        case (a)
          0: begin m_run = wd[0]; m_cen = wd[1]; m_flen = (wd >> 4) & 15; end
          1: m_ien = wd & 3;
          3: m_div = wd;
          4: m_lim = wd;
          default: ;
        endcase
      end
      void'(hist.pop_front());
      hist.push_back(cap_in);
    end
  end

  function automatic string req_of(int a);
    case (a)
      0, 1: return "R1";
      2: return "R8";
      3: return "R2";
      4: return "R3";
      5: return "R11";
      6: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always begin
    @(negedge clk); #5;
    if (started) begin
      chk("R9", irq, (m_upd & m_ien) | (m_capf & (m_ien >> 1)));
      chk(req_of(reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_wr = 1; reg_addr = a[2:0]; reg_wdata = d[15:0];
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); reg_rd = 1; reg_addr = a[2:0]; #2 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int len);
    @(negedge clk); cap_in = 1;
    repeat (len) @(negedge clk);
    cap_in = 0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    m_reset();
    idle(3); rst_n = 1; idle(4);
    started = 1;
    // R1 reset state
    rd(2, v); chk("R1", v, 0);
    rd(5, v); chk("R1", v, 0);
    rd(4, v); chk("R1", v, 65535);
    chk("R1", irq, 0);
    // R2 / R3 division and wrap
    wr(3, 3); wr(4, 9); wr(1, 1); wr(0, 1);
    idle(20); rd(5, v);
    idle(50); rd(2, v); chk("R3", v & 1, 1);
    chk("R9", irq, 1);
    wr(2, 16'hFFFE); rd(2, v); chk("R8", v & 1, 0);
    // R11 counter load
    wr(5, 5); rd(5, v); chk("R11", v, 5); idle(9); rd(5, v);
    // R5 / R6 capture and read-clear
    wr(0, 3); wr(1, 3);
    pulse(4); idle(5);
    rd(2, v); chk("R6", (v >> 1) & 1, 1);
    rd(6, v);
    rd(2, v); chk("R6", (v >> 1) & 1, 0);
    // R7 overcapture
    pulse(3); idle(3); pulse(3); idle(5);
    rd(2, v); chk("R7", (v >> 2) & 1, 1);
    wr(2, 16'hFFFB); rd(2, v); chk("R7", (v >> 2) & 1, 0);
    rd(6, v);
    // R4 filter threshold, F = 3
    wr(0, 16'h33); wr(2, 0);
    pulse(3); idle(8);
    rd(2, v); chk("R4", (v >> 1) & 1, 0);
    pulse(4); idle(8);
    rd(2, v); chk("R4", (v >> 1) & 1, 1);
    // R10 gating
    wr(0, 1); wr(2, 0); pulse(5); idle(8);
    rd(2, v); chk("R10", (v >> 1) & 1, 0);
    wr(0, 2); wr(2, 0); pulse(5); idle(8);
    rd(2, v); chk("R10", (v >> 1) & 1, 0);
    // R8 event versus clearing write on the same edge
    wr(3, 0); wr(4, 1); wr(0, 3);
    for (int i = 0; i < 12; i++) wr(2, 0);
    for (int i = 0; i < 6; i++) begin pulse(1); rd(6, v); end
    // mixed traffic, model compared every clock
    wr(4, 20);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cap_in = $urandom_range(0, 3) != 0 ? cap_in : ~cap_in;
      reg_wr = 0; reg_rd = 0;
      case ($urandom_range(0, 9))
        0: begin reg_wr = 1; reg_addr = 2; reg_wdata = 16'($urandom); end
        1: begin reg_rd = 1; reg_addr = 6; end
        2: begin reg_wr = 1; reg_addr = 0; reg_wdata = 16'($urandom_range(0, 255) | 1); end
        3: begin reg_wr = 1; reg_addr = 3; reg_wdata = 16'($urandom_range(0, 3)); end
        4: begin reg_wr = 1; reg_addr = 1; reg_wdata = 16'($urandom_range(0, 3)); end
        default: reg_addr = 3'($urandom_range(0, 7));
      endcase
    end
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule